// File: doc/BRIEF.md
# Banked Digital I/O Port Array

This block holds twelve byte-wide digital I/O groups, organised as four connectors of three groups each (A, B and C, in that order). Software chooses, group by group, whether a group is an input or a latched output. A simple register port lets a host write the output latches, the direction bits and one global run bit, and read back every group and control register.

Nothing drives a pin until the host sets the global run bit. After that, a group marked as output drives its eight pins from its latch. Tristate is shown through a separate output-enable vector, with one bit per pin. A read of an input group returns the live pin values. A read of an output group returns its latch. A write to an input group only loads the hidden latch, so the host can preload a value before it turns the group around. The latches are not cleared by reset, so software must load them before it uses them.

Address map: groups 0 to 11 sit at addresses 0 to 11. Group g belongs to connector g/3 and takes position g%3 (A=0, B=1, C=2). The direction register of connector k sits at address 16+k. The run bit sits at address 20. All other addresses are unmapped.

Top module: `dio_bank`

## Requirements
- R1: While rst_n is low, and at the first cycle after it rises, every direction bit and the run bit are 0 and every bit of pin_oe is 0.
- R2: The run bit is bit 0 of address 20 and reads back there. While it is 0, every bit of pin_oe is 0 whatever the directions are.
- R3: The pin_oe bits of group g are all 1 exactly when the run bit is 1 and group g is set as output, and all 0 otherwise. pin_out of a driven group equals its latch, and pin_out is 0 wherever pin_oe is 0.
- R4: The direction register of connector k is at address 16+k. Bit j (0 to 2) selects group 3k+j, and 1 means output. Only bits [2:0] are stored, and reads return them with the upper bits at 0.
- R5: With the run bit at 1, a read of an input group g returns pin_in[8g+7:8g].
- R6: With the run bit at 1, a read of an output group returns its latch, whatever the pins carry.
- R7: A write to an input group changes neither its read value nor its pins. Its latch is still loaded, and the new value appears once the group is switched to output.
- R8: While the run bit is 0, reads of addresses 0 to 11 return 0. Latch and direction writes still take effect.
- R9: Addresses 12 to 15 and 21 to 31 read as 0, and a write to any of them changes no register, read value or pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the direction bits and the run bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address (combinational read) |
| rd_data | output | 8 | Read data |
| pin_in | input | 96 | External pin levels, group g on bits [8g+7:8g] |
| pin_out | output | 96 | Pin drive values |
| pin_oe | output | 96 | Per-pin output enable |

## Verification
The hardest case to reach is a group's hidden latch changing while the group is still an input, and then coming into view when the direction flips. The reads and pins give no sign of the change until that flip happens. Directed steps preload an input group, check that the pins and the read value stay fixed, and only then turn the group to output. The random phase mixes latch writes, direction flips, run-bit toggles, unmapped writes and fresh pin patterns. This keeps latches that were loaded long ago surfacing at arbitrary later points, and each one is checked against a bench model.

// File: rtl/dio_bank.sv
module dio_bank #(
  parameter int CONNS   = 4,
  parameter int GRP_PER = 3,
  parameter int GW      = 8,
  parameter int AW      = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [GW-1:0]                 wr_data,
  input  logic [AW-1:0]                 rd_addr,
  output logic [GW-1:0]                 rd_data,
  input  logic [CONNS*GRP_PER*GW-1:0]   pin_in,
  output logic [CONNS*GRP_PER*GW-1:0]   pin_out,
  output logic [CONNS*GRP_PER*GW-1:0]   pin_oe
);
  localparam int NG       = CONNS * GRP_PER;
  localparam int DIR_BASE = 1 << $clog2(NG);
  localparam int EN_ADDR  = DIR_BASE + CONNS;

  logic [GW-1:0] lat [NG];
  logic [NG-1:0] dir_q;
  logic          en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else if (wr_en && wr_addr == AW'(EN_ADDR)) en_q <= wr_data[0];

  for (genvar k = 0; k < CONNS; k++) begin : g_conn
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dir_q[k*GRP_PER +: GRP_PER] <= '0;
      else if (wr_en && wr_addr == AW'(DIR_BASE + k))
        dir_q[k*GRP_PER +: GRP_PER] <= wr_data[GRP_PER-1:0];
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk)
      if (wr_en && wr_addr == AW'(g)) lat[g] <= wr_data;
    assign pin_oe[g*GW +: GW]  = {GW{en_q & dir_q[g]}};
    assign pin_out[g*GW +: GW] = lat[g] & pin_oe[g*GW +: GW];
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NG; g++)
      if (rd_addr == AW'(g) && en_q)
        rd_data = dir_q[g] ? lat[g] : pin_in[g*GW +: GW];
    for (int k = 0; k < CONNS; k++)
      if (rd_addr == AW'(DIR_BASE + k))
        rd_data = GW'(dir_q[k*GRP_PER +: GRP_PER]);
    if (rd_addr == AW'(EN_ADDR)) rd_data = GW'(en_q);
  end
endmodule

module dio_bank_chk #(
  parameter int CONNS   = 4,
  parameter int GRP_PER = 3,
  parameter int GW      = 8,
  parameter int AW      = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [AW-1:0]               rd_addr,
  input logic [GW-1:0]               rd_data,
  input logic [CONNS*GRP_PER*GW-1:0] pin_in,
  input logic [CONNS*GRP_PER*GW-1:0] pin_out,
  input logic [CONNS*GRP_PER*GW-1:0] pin_oe,
  input logic [CONNS*GRP_PER-1:0]    dir_q,
  input logic                        en_q
);
  localparam int NG = CONNS * GRP_PER;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_oe == '0)); // R1
  AST_OE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pin_oe == '0)); // R2
  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R3
  AST_OFF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && rd_addr < AW'(NG)) |-> (rd_data == '0)); // R8

  for (genvar g = 0; g < NG; g++) begin : g_chk
    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe[g*GW +: GW] == '0) || (pin_oe[g*GW +: GW] == '1)); // R3
    AST_PIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !dir_q[g] && rd_addr == AW'(g)) |-> (rd_data == pin_in[g*GW +: GW])); // R5
  end
endmodule

bind dio_bank dio_bank_chk #(.CONNS(CONNS), .GRP_PER(GRP_PER), .GW(GW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .dir_q(dir_q), .en_q(en_q));

// File: tb/sim_dio_bank.sv
`timescale 1ns/1ps
module sim_dio_bank;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0]  wr_addr = 0, rd_addr = 0;
  logic [7:0]  wr_data = 0, rd_data;
  logic [95:0] pin_in = 0, pin_out, pin_oe;
  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0]  m_lat [12];
  logic [11:0] m_dir = 0;
  logic        m_en = 0;

  always #5 clk = ~clk;

  dio_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
               .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [7:0] exp_read(input int a);
    if (a < 12) return m_en ? (m_dir[a] ? m_lat[a] : pin_in[a*8 +: 8]) : 8'h00;
    if (a >= 16 && a < 20) return {5'b0, m_dir[(a-16)*3 +: 3]};
    if (a == 20) return {7'b0, m_en};
    return 8'h00;
  endfunction

  function automatic logic [95:0] exp_oe();
    logic [95:0] v;
    for (int g = 0; g < 12; g++) v[g*8 +: 8] = {8{m_en & m_dir[g]}};
    return v;
  endfunction

  function automatic logic [95:0] exp_out();
    logic [95:0] v;
    for (int g = 0; g < 12; g++) v[g*8 +: 8] = (m_en & m_dir[g]) ? m_lat[g] : 8'h00;
    return v;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = d;
    if (a < 12) m_lat[a] = d;
    else if (a >= 16 && a < 20) m_dir[(a-16)*3 +: 3] = d[2:0];
    else if (a == 20) m_en = d[0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk_rd(input int a, input string req);
    logic [7:0] e;
    rd_addr = 5'(a); #1;
    e = exp_read(a);
    tests++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s read addr %0d: got %h expected %h", req, a, rd_data, e);
    end
  endtask

  task automatic chk_pins(input string req);
    #1;
    tests++;
    if (pin_oe !== exp_oe() || pin_out !== exp_out()) begin
      fails++;
      $display("FAIL %s pins: oe %h out %h expected oe %h out %h", req, pin_oe, pin_out, exp_oe(), exp_out());
    end
  endtask

  initial begin
    #(200000*10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < 12; g++) m_lat[g] = 8'h00;
    pin_in = {$urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    chk_pins("R1");
    rst_n = 1;
    @(negedge clk);
    chk_pins("R1");
    for (int k = 0; k < 4; k++) chk_rd(16 + k, "R1");
    chk_rd(20, "R1");

    for (int g = 0; g < 12; g++) wr(g, 8'(8'h30 + g * 7));
    wr(17, 8'hFF);
    chk_rd(4, "R8");
    chk_rd(17, "R8");
    chk_pins("R2");
    wr(17, 8'h00);

    wr(20, 8'h01);
    chk_rd(20, "R2");
    for (int g = 0; g < 12; g++) chk_rd(g, "R5");
    chk_pins("R3");

    wr(17, 8'hF5);
    chk_rd(17, "R4");
    pin_in = ~pin_in;
    chk_rd(3, "R6");
    chk_rd(5, "R6");
    chk_rd(4, "R5");
    chk_pins("R3");

    wr(4, 8'hA5);
    chk_rd(4, "R7");
    chk_pins("R7");
    wr(17, 8'h07);
    chk_rd(4, "R7");
    chk_pins("R7");

    wr(13, 8'hFF);
    wr(25, 8'hFF);
    chk_rd(13, "R9");
    chk_rd(25, "R9");
    for (int g = 0; g < 12; g++) chk_rd(g, "R9");
    chk_pins("R9");

    wr(20, 8'h00);
    chk_pins("R2");
    chk_rd(3, "R8");

    for (int i = 0; i < 3000; i++) begin
      int a;
      a = int'($urandom % 32);
      if (a >= 16 && a <= 20 && ($urandom % 2) == 0) wr(a, 8'($urandom));
      else if (a < 16) wr(a, 8'($urandom));
      else wr(int'($urandom % 32), 8'($urandom));
      if ($urandom % 4 == 0) pin_in = {$urandom, $urandom, $urandom};
      chk_rd(int'($urandom % 32), "R3 R4 R5 R6 R7 R8 R9 random");
      chk_pins("R2 R3 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule